// File: doc/BRIEF.md
# Embedded video sync code decoder

This block recovers frame and line boundaries of a parallel video stream from synchronization codes carried inside the data bytes themselves, so a sensor needs no separate sync wires. Software programs four code values (frame start, line start, line end, frame end). Each code has its own unmask pattern, so only the chosen bits of an incoming byte take part in the comparison. An ordering state machine accepts only the legal sequence of codes and raises a one-cycle error pulse when the sequence is broken.

All decisions are taken on cycles where `sample_en` is high; `sample_en` marks the active edge of the pixel clock after it has been brought into the system clock domain. A mode input chooses between decoding embedded codes and following the dedicated frame and line sync inputs. Embedded decoding is forced off while the compressed-stream mode is active, because compressed data may contain any byte value.

Top module: `sync_code_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `frame_active`, `line_active`, `data_valid`, `sync_err` and `data_out` are all 0.
- R2: A byte hits a code when `((data_in ^ code) & unmask) == 0`; unmask bits at 0 are don't-care bits, so an unmask of all zeros hits every byte.
- R3: In embedded mode with no frame open, a byte hitting the frame-start code opens a frame: `frame_active` reads 1 one cycle after the sampled cycle. Bytes hitting no code leave the decoder idle.
- R4: Inside an open frame, a line-start hit sets `line_active`, a line-end hit inside a line clears it, and a frame-end hit between lines closes the frame. `line_active` is never 1 while `frame_active` is 0.
- R5: A sampled byte hitting no code while a line is open gives a one-cycle `data_valid` pulse in the next cycle, with that byte on `data_out`; a code byte never gives `data_valid`.
- R6: Any code hit that is not legal in the current state pulses `sync_err` for one cycle and returns the decoder to idle (frame and line inactive). Legal moves are: idle to frame on frame start, frame to line on line start, line to frame on line end, frame to idle on frame end.
- R7: On cycles with `sample_en` low, `frame_active` and `line_active` keep their values, and `data_valid` and `sync_err` are 0 one cycle later.
- R8: With `embedded_mode` 0, each sampled cycle loads `frame_active` from `hw_frame`, `line_active` and `data_valid` from `hw_frame & hw_line`, ignores code values, never raises `sync_err`, and resets the ordering state to idle.
- R9: With `compressed_mode` 1 the block behaves as in R8 even when `embedded_mode` is 1.
- R10: When a byte hits several codes, the code that is legal in the current state wins: frame start when idle, line start before frame end between lines, line end inside a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | High for one cycle per active pixel-clock edge |
| embedded_mode | input | 1 | 1 selects embedded code decoding, 0 selects the sync inputs |
| compressed_mode | input | 1 | 1 disables embedded decoding |
| hw_frame | input | 1 | Dedicated frame sync, active high |
| hw_line | input | 1 | Dedicated line sync, active high |
| data_in | input | DATA_W | Incoming pixel byte |
| code_fs | input | DATA_W | Frame-start code |
| code_ls | input | DATA_W | Line-start code |
| code_le | input | DATA_W | Line-end code |
| code_fe | input | DATA_W | Frame-end code |
| unmask_fs | input | DATA_W | Compare mask for frame start |
| unmask_ls | input | DATA_W | Compare mask for line start |
| unmask_le | input | DATA_W | Compare mask for line end |
| unmask_fe | input | DATA_W | Compare mask for frame end |
| frame_active | output | 1 | A frame is open |
| line_active | output | 1 | A line is open |
| data_valid | output | 1 | One-cycle pulse: `data_out` holds a pixel byte |
| data_out | output | DATA_W | Last accepted pixel byte |
| sync_err | output | 1 | One-cycle pulse on an illegal code order |

## Verification
The bench targets masked matches where a byte differs from a code only in don't-care bits; a decoder that compared all bits would miss the frame start. It makes one byte hit several codes through an all-zero unmask, where a fixed priority instead of a state-driven one would close the frame instead of opening a line. It walks every illegal code in every state, where a decoder that forgot to return to idle would keep `frame_active` high after the error pulse, and it flips the mode inputs mid-stream to catch a decoder that still decodes codes when compressed mode is active. Idle cycles with a code on the data bus catch a decoder that samples without `sample_en`.

// File: rtl/scd_pkg.sv
package scd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_LINE  = 2'd2
   } scd_state_e;

   localparam int unsigned NUM_CODES = 4;
   localparam int unsigned IDX_FS = 0;
   localparam int unsigned IDX_LS = 1;
   localparam int unsigned IDX_LE = 2;
   localparam int unsigned IDX_FE = 3;
endpackage

// File: rtl/scd_code_match.sv
module scd_code_match #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] code_i,
   input  logic [DATA_W-1:0] unmask_i,
   output logic              hit_o
);
   logic [DATA_W-1:0] diff;
   assign diff  = (byte_i ^ code_i) & unmask_i;
   assign hit_o = (diff == '0);
endmodule

// File: rtl/scd_order_fsm.sv
module scd_order_fsm
   import scd_pkg::*;
#(
   parameter int unsigned N_CODES = NUM_CODES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance_i,
   input  logic               flush_i,
   input  logic [N_CODES-1:0] hit_i,
   output scd_state_e         next_o,
   output logic               pixel_o,
   output logic               err_o
);
   scd_state_e state_q;
   logic       any_hit;

   assign any_hit = |hit_i;

   always_comb begin
      next_o  = state_q;
      pixel_o = 1'b0;
      err_o   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (hit_i[IDX_FS])   next_o = ST_FRAME;
            else if (any_hit)    err_o  = 1'b1;
         end
         ST_FRAME: begin
            if (hit_i[IDX_LS])      next_o = ST_LINE;
            else if (hit_i[IDX_FE]) next_o = ST_IDLE;
            else if (any_hit) begin
               err_o  = 1'b1;
               next_o = ST_IDLE;
            end
         end
         ST_LINE: begin
            if (hit_i[IDX_LE])   next_o = ST_FRAME;
            else if (any_hit) begin
               err_o  = 1'b1;
               next_o = ST_IDLE;
            end
            else                 pixel_o = 1'b1;
         end
         default:                next_o = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         state_q <= ST_IDLE;
      else if (flush_i)   state_q <= ST_IDLE;
      else if (advance_i) state_q <= next_o;
   end
endmodule

// File: rtl/sync_code_decoder.sv
module sync_code_decoder
   import scd_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              embedded_mode,
   input  logic              compressed_mode,
   input  logic              hw_frame,
   input  logic              hw_line,
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] code_fs,
   input  logic [DATA_W-1:0] code_ls,
   input  logic [DATA_W-1:0] code_le,
   input  logic [DATA_W-1:0] code_fe,
   input  logic [DATA_W-1:0] unmask_fs,
   input  logic [DATA_W-1:0] unmask_ls,
   input  logic [DATA_W-1:0] unmask_le,
   input  logic [DATA_W-1:0] unmask_fe,
   output logic              frame_active,
   output logic              line_active,
   output logic              data_valid,
   output logic [DATA_W-1:0] data_out,
   output logic              sync_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_code_decoder: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0]    code_arr   [NUM_CODES];
   logic [DATA_W-1:0]    unmask_arr [NUM_CODES];
   logic [NUM_CODES-1:0] hits;
   logic                 emb_on;
   scd_state_e           nxt_state;
   logic                 pix_hit;
   logic                 order_err;

   assign code_arr[IDX_FS]   = code_fs;
   assign code_arr[IDX_LS]   = code_ls;
   assign code_arr[IDX_LE]   = code_le;
   assign code_arr[IDX_FE]   = code_fe;
   assign unmask_arr[IDX_FS] = unmask_fs;
   assign unmask_arr[IDX_LS] = unmask_ls;
   assign unmask_arr[IDX_LE] = unmask_le;
   assign unmask_arr[IDX_FE] = unmask_fe;

   assign emb_on = embedded_mode & ~compressed_mode;

   for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_match
      scd_code_match #(.DATA_W(DATA_W)) u_match (
         .byte_i   (data_in),
         .code_i   (code_arr[gi]),
         .unmask_i (unmask_arr[gi]),
         .hit_o    (hits[gi])
      );
   end

   scd_order_fsm #(.N_CODES(NUM_CODES)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (sample_en & emb_on),
      .flush_i   (sample_en & ~emb_on),
      .hit_i     (hits),
      .next_o    (nxt_state),
      .pixel_o   (pix_hit),
      .err_o     (order_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_active <= 1'b0;
         line_active  <= 1'b0;
         data_valid   <= 1'b0;
         data_out     <= '0;
         sync_err     <= 1'b0;
      end else begin
         data_valid <= 1'b0;
         sync_err   <= 1'b0;
         if (sample_en) begin
            if (emb_on) begin
               frame_active <= (nxt_state != ST_IDLE);
               line_active  <= (nxt_state == ST_LINE);
               data_valid   <= pix_hit;
               sync_err     <= order_err;
               if (pix_hit) data_out <= data_in;
            end else begin
               frame_active <= hw_frame;
               line_active  <= hw_frame & hw_line;
               data_valid   <= hw_frame & hw_line;
               if (hw_frame & hw_line) data_out <= data_in;
            end
         end
      end
   end
endmodule

// File: rtl/scd_checker.sv
module scd_checker (
   input logic clk,
   input logic rst_n,
   input logic sample_en,
   input logic embedded_mode,
   input logic compressed_mode,
   input logic frame_active,
   input logic line_active,
   input logic data_valid,
   input logic sync_err
);
   AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      line_active |-> frame_active); // R4
   AST_VALID_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> line_active); // R5
   AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> (!frame_active && !line_active)); // R6
   AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> ($stable(frame_active) && $stable(line_active) && !data_valid && !sync_err)); // R7
   AST_HW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!embedded_mode || compressed_mode) |=> !sync_err); // R8
endmodule

bind sync_code_decoder scd_checker u_scd_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .sample_en       (sample_en),
   .embedded_mode   (embedded_mode),
   .compressed_mode (compressed_mode),
   .frame_active    (frame_active),
   .line_active     (line_active),
   .data_valid      (data_valid),
   .sync_err        (sync_err)
);

// File: tb/tb_sync_code_decoder.sv
module tb_sync_code_decoder;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b0;
   logic       embedded_mode = 1'b1;
   logic       compressed_mode = 1'b0;
   logic       hw_frame = 1'b0;
   logic       hw_line = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic [7:0] code_fs = 8'hA0, code_ls = 8'h80, code_le = 8'h9D, code_fe = 8'hB0;
   logic [7:0] unmask_fs = 8'hF0, unmask_ls = 8'hFF, unmask_le = 8'hFF, unmask_fe = 8'hF0;
   logic       frame_active, line_active, data_valid, sync_err;
   logic [7:0] data_out;

   int n_checks = 0;
   int n_errors = 0;
   int m_state  = 0;
   logic e_fa = 1'b0, e_la = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_code_decoder #(.DATA_W(8)) dut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] bench_hits(input logic [7:0] b);
      logic [3:0] h;
      h[0] = ((b ^ code_fs) & unmask_fs) == 8'h00;
      h[1] = ((b ^ code_ls) & unmask_ls) == 8'h00;
      h[2] = ((b ^ code_le) & unmask_le) == 8'h00;
      h[3] = ((b ^ code_fe) & unmask_fe) == 8'h00;
      return h;
   endfunction

   task automatic send(input logic [7:0] b);
      logic [3:0] h;
      logic e_dv, e_err;
      h = bench_hits(b);
      e_dv = 1'b0; e_err = 1'b0;
      if (!embedded_mode || compressed_mode) begin
         m_state = 0;
         e_fa = hw_frame;
         e_la = hw_frame & hw_line;
         e_dv = e_la;
      end else begin
         case (m_state)
            0: if (h[0]) m_state = 1; else if (|h) e_err = 1'b1;
            1: if (h[1]) m_state = 2; else if (h[3]) m_state = 0;
               else if (|h) begin e_err = 1'b1; m_state = 0; end
            default: if (h[2]) m_state = 1;
               else if (|h) begin e_err = 1'b1; m_state = 0; end
               else e_dv = 1'b1;
         endcase
         e_fa = (m_state != 0);
         e_la = (m_state == 2);
      end
      @(negedge clk);
      data_in = b; sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
      chk(frame_active == e_fa, "R3", "frame_active", frame_active, e_fa);
      chk(line_active == e_la, "R4", "line_active", line_active, e_la);
      chk(data_valid == e_dv, "R5", "data_valid", data_valid, e_dv);
      chk(sync_err == e_err, "R6", "sync_err", sync_err, e_err);
      if (e_dv) chk(data_out == b, "R5", "data_out", data_out, b);
   endtask

   task automatic idle_cycle(input logic [7:0] b);
      data_in = b;
      @(negedge clk);
      chk(frame_active == e_fa && line_active == e_la, "R7", "hold state",
          {frame_active, line_active}, {e_fa, e_la});
      chk(!data_valid && !sync_err, "R7", "no pulse", {data_valid, sync_err}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk({frame_active, line_active, data_valid, sync_err, data_out} == 12'h0, "R1", "reset outputs",
          {frame_active, line_active, data_valid, sync_err, data_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({frame_active, line_active, data_valid, sync_err, data_out} == 12'h0, "R1", "after reset",
          {frame_active, line_active, data_valid, sync_err, data_out}, 0);

      // R3: idle data ignored, then frame start
      send(8'h11);
      send(8'hA0);
      chk(frame_active == 1'b1, "R3", "frame opened", frame_active, 1);
      // R4 / R5: line and pixel
      send(8'h80);
      send(8'h42);
      chk(data_out == 8'h42, "R5", "pixel out", data_out, 8'h42);
      // R7: code on bus without sample_en
      idle_cycle(8'hB0);
      idle_cycle(8'h9D);
      send(8'h9D);
      // R2: masked frame end (B3 differs only in don't-care bits)
      send(8'hB3);
      chk(frame_active == 1'b0, "R2", "masked frame end", frame_active, 0);
      send(8'hA7);
      chk(frame_active == 1'b1, "R2", "masked frame start", frame_active, 1);
      // R6: line end between lines, then line start when idle
      send(8'h9D);
      chk(sync_err == 1'b1 && frame_active == 1'b0, "R6", "LE in frame", {sync_err, frame_active}, 2);
      send(8'h80);
      chk(sync_err == 1'b1, "R6", "LS when idle", sync_err, 1);
      send(8'hA0); send(8'h80); send(8'hA1);
      chk(sync_err == 1'b1 && line_active == 1'b0, "R6", "FS in line", {sync_err, line_active}, 2);

      // R10: frame-end unmask all zero hits every byte
      unmask_fe = 8'h00;
      send(8'hA0);
      chk(frame_active == 1'b1, "R10", "FS wins when idle", frame_active, 1);
      send(8'h80);
      chk(line_active == 1'b1, "R10", "LS wins over FE", line_active, 1);
      send(8'h9D);
      chk(line_active == 1'b0 && frame_active == 1'b1, "R10", "LE wins in line", {frame_active, line_active}, 2);
      send(8'h55);
      chk(frame_active == 1'b0, "R10", "FE closes frame", frame_active, 0);
      unmask_fe = 8'hF0;

      // R9: compressed mode blocks embedded decoding
      compressed_mode = 1'b1;
      send(8'hA0);
      chk(frame_active == 1'b0, "R9", "code ignored", frame_active, 0);
      hw_frame = 1'b1; hw_line = 1'b1;
      send(8'h33);
      chk(data_valid == 1'b1 && data_out == 8'h33, "R9", "hw pixel", data_out, 8'h33);
      compressed_mode = 1'b0;

      // R8: hardware sync mode
      embedded_mode = 1'b0;
      hw_line = 1'b0;
      send(8'h9D);
      chk(frame_active && !line_active && !sync_err, "R8", "hw frame only",
          {frame_active, line_active, sync_err}, 4);
      hw_frame = 1'b0;
      send(8'h80);
      embedded_mode = 1'b1;

      // random stream: codes, near codes and data
      for (int i = 0; i < 800; i++) begin
         int unsigned r;
         logic [7:0] b;
         r = $urandom % 10;
         case (r)
            0: b = 8'hA0 | 8'($urandom % 16);
            1, 2: b = 8'h80;
            3, 4: b = 8'h9D;
            5: b = 8'hB0 | 8'($urandom % 16);
            default: b = 8'($urandom);
         endcase
         if (($urandom % 8) == 0) idle_cycle(8'($urandom));
         send(b);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule